// File: doc/BRIEF.md
# Translation Miss Request Tracker

This block sits between a requester that has already merged per-lane translation requests and the storage array of a translation lookaside buffer. Each incoming request names one virtual page and carries the number of lanes merged into it plus a prefetch flag. In the cycle a request is taken, the array reports hit or miss for that page. A hit is answered after a fixed hit delay. A miss waits a separate miss delay and then goes downward. That destination is a lower-level translation buffer or, when the block is configured as the last level, a page-walk engine.

The tracker holds at most `MAX_OUT` translations in flight, and at most one pending record per virtual page. Records live in a small content-addressed table whose depth equals that cap. A reply from below is matched to its record by page number. The reply is written back into the local array through an insert strobe and then returned upstream. A returned record spends one cycle in cleanup before its slot can be reused. Lane counts of hits and misses from non-prefetch traffic are accumulated, and the highest number of translations ever in flight is kept.

Top module: `xmt_tracker`

## Requirements
- R1: After reset, `req_ready` is 1; `out_valid`, `dn_valid`, `walk_valid` and `ins_valid` are 0; `outstanding`, `peak_outstanding`, `hit_lanes` and `miss_lanes` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 whenever `outstanding` equals `MAX_OUT`, or when no slot is free, or when the page is already pending. A refused requester must hold and retry.
- R3: If `req_vpn` matches a pending record, `dup_err` is 1 in that same cycle and `req_ready` is 0. After the record is returned upstream, that page is no longer pending.
- R4: A request taken with `tlb_hit`=1 at clock edge E gives `out_valid`=1 after edge E+`HIT_LAT` (HIT_LAT at least 1), not before. At that point `out_hit`=1, and `out_vpn`, `out_ppn` and `out_lanes` equal the values sampled at E.
- R5: With `LAST_LEVEL`=0, a request taken with `tlb_hit`=0 at edge E raises `dn_valid` after edge E+`MISS_LAT` (MISS_LAT at least 1), with `dn_vpn` equal to its page.
- R6: With `LAST_LEVEL`=1, misses go out on `walk_valid`/`walk_vpn` with the same timing, and `dn_valid` stays 0. The two valids are never both 1.
- R7: While the downward valid is 1 and its ready is 0, the valid stays 1 and the page stays stable. One request leaves per edge with ready 1, in ascending slot order.
- R8: A reply (`rsp_valid`) whose `rsp_vpn` matches a record waiting for a reply raises `ins_valid` in the same cycle, with `ins_vpn`/`ins_ppn` copied from the reply. After the next edge, `out_valid` is 1 with `out_hit`=0 and `out_ppn`=`rsp_ppn`. A reply matching no waiting record is ignored: `ins_valid` stays 0 and no response follows.
- R9: Each record raises `out_valid` for exactly one cycle, lowest slot first. `outstanding` drops by one after that edge, and it rises by one after each edge that takes a request.
- R10: `hit_lanes` and `miss_lanes` add `req_lanes` after each edge that takes a non-prefetch hit or miss. A prefetch request (`req_prefetch`=1) leaves both unchanged.
- R11: `peak_outstanding` equals the largest value `outstanding` has held since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Merged translation request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vpn | input | VPN_W | Virtual page of the request |
| req_lanes | input | LANE_W | Number of merged lane requests |
| req_prefetch | input | 1 | Request is a prefetch |
| tlb_hit | input | 1 | Array hit for `req_vpn` |
| tlb_ppn | input | PPN_W | Physical page from the array on a hit |
| dup_err | output | 1 | Request names a page already pending |
| dn_valid | output | 1 | Miss request to the lower-level buffer |
| dn_ready | input | 1 | Lower level takes the miss request |
| dn_vpn | output | VPN_W | Page sent to the lower level |
| walk_valid | output | 1 | Page-walk request (last level) |
| walk_ready | input | 1 | Walker takes the request |
| walk_vpn | output | VPN_W | Page sent to the walker |
| rsp_valid | input | 1 | Reply from below present |
| rsp_vpn | input | VPN_W | Page of the reply |
| rsp_ppn | input | PPN_W | Physical page of the reply |
| ins_valid | output | 1 | Write the reply into the local array |
| ins_vpn | output | VPN_W | Page to insert |
| ins_ppn | output | PPN_W | Physical page to insert |
| out_valid | output | 1 | Completed translation returned upstream |
| out_vpn | output | VPN_W | Page of the returned translation |
| out_ppn | output | PPN_W | Physical page of the returned translation |
| out_hit | output | 1 | Returned translation was a local hit |
| out_lanes | output | LANE_W | Lane count of the returned translation |
| outstanding | output | $clog2(MAX_OUT+1) | Translations currently in flight |
| peak_outstanding | output | $clog2(MAX_OUT+1) | Highest in-flight count since reset |
| hit_lanes | output | CNT_W | Accumulated non-prefetch hit lanes |
| miss_lanes | output | CNT_W | Accumulated non-prefetch miss lanes |

## Verification
A corrupted slot state shows up as a response that arrives a cycle early or late against the fixed hit and miss delays. It can also show up as a miss that never appears on the downward port, or a reply that produces no insert strobe. All of these are visible within `MISS_LAT`+2 cycles of the request. A wrong pending-record key appears at once as a false `dup_err`, or as a missing one, on the next request for the same page. A drifting in-flight count appears as `req_ready` falling before the cap is really reached, or as `outstanding` failing to return to zero when the bench drains.

// File: rtl/xmt_pkg.sv
package xmt_pkg;

    typedef enum logic [2:0] {
        S_FREE  = 3'd0,
        S_HITW  = 3'd1,
        S_MISSW = 3'd2,
        S_SEND  = 3'd3,
        S_RSPW  = 3'd4,
        S_DONE  = 3'd5,
        S_CLEAN = 3'd6
    } slot_st_e;

    function automatic logic st_pending(input slot_st_e s);
        return (s != S_FREE) && (s != S_CLEAN);
    endfunction

endpackage

// File: rtl/xmt_lowpick.sv
module xmt_lowpick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xmt_cam.sv
module xmt_cam #(
    parameter int N  = 4,
    parameter int VW = 20
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0]         rspw,
    input  logic [N-1:0][VW-1:0] keys,
    input  logic [VW-1:0]        q_req,
    input  logic [VW-1:0]        q_rsp,
    output logic                 req_hit,
    output logic [N-1:0]         rsp_match
);
    logic [N-1:0] eq_req;

    for (genvar g = 0; g < N; g++) begin : g_row
        assign eq_req[g]    = pend[g] && (keys[g] == q_req);
        assign rsp_match[g] = rspw[g] && (keys[g] == q_rsp);
    end

    assign req_hit = |eq_req;
endmodule

// File: rtl/xmt_stats.sv
module xmt_stats #(
    parameter int LW = 6,
    parameter int CW = 32,
    parameter int OW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          is_hit,
    input  logic          is_pf,
    input  logic [LW-1:0] lanes,
    input  logic [OW-1:0] outst_d,
    output logic [CW-1:0] hit_cnt,
    output logic [CW-1:0] miss_cnt,
    output logic [OW-1:0] peak
);
    typedef struct packed {
        logic [CW-1:0] hit;
        logic [CW-1:0] miss;
        logic [OW-1:0] peak;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take && !is_pf) begin
            if (is_hit) s_d.hit  = s_q.hit + CW'(lanes);
            else        s_d.miss = s_q.miss + CW'(lanes);
        end
        if (outst_d > s_q.peak) s_d.peak = outst_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_cnt  = s_q.hit;
    assign miss_cnt = s_q.miss;
    assign peak     = s_q.peak;
endmodule

// File: rtl/xmt_tracker.sv
module xmt_tracker
    import xmt_pkg::*;
#(
    parameter int VPN_W      = 20,
    parameter int PPN_W      = 20,
    parameter int LANE_W     = 6,
    parameter int CNT_W      = 32,
    parameter int MAX_OUT    = 4,
    parameter int HIT_LAT    = 2,
    parameter int MISS_LAT   = 3,
    parameter bit LAST_LEVEL = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [VPN_W-1:0]             req_vpn,
    input  logic [LANE_W-1:0]            req_lanes,
    input  logic                         req_prefetch,
    input  logic                         tlb_hit,
    input  logic [PPN_W-1:0]             tlb_ppn,
    output logic                         dup_err,
    output logic                         dn_valid,
    input  logic                         dn_ready,
    output logic [VPN_W-1:0]             dn_vpn,
    output logic                         walk_valid,
    input  logic                         walk_ready,
    output logic [VPN_W-1:0]             walk_vpn,
    input  logic                         rsp_valid,
    input  logic [VPN_W-1:0]             rsp_vpn,
    input  logic [PPN_W-1:0]             rsp_ppn,
    output logic                         ins_valid,
    output logic [VPN_W-1:0]             ins_vpn,
    output logic [PPN_W-1:0]             ins_ppn,
    output logic                         out_valid,
    output logic [VPN_W-1:0]             out_vpn,
    output logic [PPN_W-1:0]             out_ppn,
    output logic                         out_hit,
    output logic [LANE_W-1:0]            out_lanes,
    output logic [$clog2(MAX_OUT+1)-1:0] outstanding,
    output logic [$clog2(MAX_OUT+1)-1:0] peak_outstanding,
    output logic [CNT_W-1:0]             hit_lanes,
    output logic [CNT_W-1:0]             miss_lanes
);
    localparam int OC_W    = $clog2(MAX_OUT + 1);
    localparam int IDX_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
    localparam int LAT_MAX = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
    localparam int LAT_W   = $clog2(LAT_MAX + 1);

    typedef struct packed {
        slot_st_e             st;
        logic [VPN_W-1:0]     vpn;
        logic [PPN_W-1:0]     ppn;
        logic                 hit;
        logic [LANE_W-1:0]    lanes;
        logic [LAT_W-1:0]     cnt;
    } slot_t;

    typedef struct packed {
        slot_t [MAX_OUT-1:0]  slot;
        logic [OC_W-1:0]      outst;
        logic                 snd_busy;
        logic [IDX_W-1:0]     snd_idx;
    } regs_t;

    regs_t r_d, r_q;

    logic [MAX_OUT-1:0]            free_vec, done_vec, send_vec, pend_vec, rspw_vec;
    logic [MAX_OUT-1:0][VPN_W-1:0] key_vec;
    logic [MAX_OUT-1:0]            free_gnt, done_gnt, send_gnt, rsp_match;
    logic [IDX_W-1:0]              free_idx, done_idx, send_idx, sel_idx;
    logic                          free_any, done_any, send_any;
    logic                          req_pend, accept, down_ready, take, rsp_hit;

    for (genvar g = 0; g < MAX_OUT; g++) begin : g_vec
        assign free_vec[g] = (r_q.slot[g].st == S_FREE);
        assign done_vec[g] = (r_q.slot[g].st == S_DONE);
        assign send_vec[g] = (r_q.slot[g].st == S_SEND);
        assign rspw_vec[g] = (r_q.slot[g].st == S_RSPW);
        assign pend_vec[g] = st_pending(r_q.slot[g].st);
        assign key_vec[g]  = r_q.slot[g].vpn;
    end

    xmt_cam #(.N(MAX_OUT), .VW(VPN_W)) u_cam (
        .pend      (pend_vec),
        .rspw      (rspw_vec),
        .keys      (key_vec),
        .q_req     (req_vpn),
        .q_rsp     (rsp_vpn),
        .req_hit   (req_pend),
        .rsp_match (rsp_match)
    );

    xmt_lowpick #(.N(MAX_OUT), .IW(IDX_W)) u_pick_free (
        .req (free_vec), .gnt (free_gnt), .idx (free_idx), .any (free_any)
    );
    xmt_lowpick #(.N(MAX_OUT), .IW(IDX_W)) u_pick_done (
        .req (done_vec), .gnt (done_gnt), .idx (done_idx), .any (done_any)
    );
    xmt_lowpick #(.N(MAX_OUT), .IW(IDX_W)) u_pick_send (
        .req (send_vec), .gnt (send_gnt), .idx (send_idx), .any (send_any)
    );

    assign req_ready  = (r_q.outst < OC_W'(MAX_OUT)) && free_any && !req_pend;
    assign dup_err    = req_valid && req_pend;
    assign accept     = req_valid && req_ready;
    assign sel_idx    = r_q.snd_busy ? r_q.snd_idx : send_idx;
    assign down_ready = LAST_LEVEL ? walk_ready : dn_ready;
    assign take       = send_any && down_ready;
    assign rsp_hit    = rsp_valid && (|rsp_match);

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < MAX_OUT; i++) begin
            case (r_q.slot[i].st)
                S_FREE: begin
                    if (accept && free_gnt[i]) begin
                        r_d.slot[i].st    = tlb_hit ? S_HITW : S_MISSW;
                        r_d.slot[i].cnt   = tlb_hit ? LAT_W'(HIT_LAT) : LAT_W'(MISS_LAT);
                        r_d.slot[i].vpn   = req_vpn;
                        r_d.slot[i].ppn   = tlb_ppn;
                        r_d.slot[i].hit   = tlb_hit;
                        r_d.slot[i].lanes = req_lanes;
                    end
                end
                S_HITW: begin
                    if (r_q.slot[i].cnt == LAT_W'(1)) r_d.slot[i].st = S_DONE;
                    else r_d.slot[i].cnt = r_q.slot[i].cnt - LAT_W'(1);
                end
                S_MISSW: begin
                    if (r_q.slot[i].cnt == LAT_W'(1)) r_d.slot[i].st = S_SEND;
                    else r_d.slot[i].cnt = r_q.slot[i].cnt - LAT_W'(1);
                end
                S_SEND: begin
                    if (take && (sel_idx == IDX_W'(i))) r_d.slot[i].st = S_RSPW;
                end
                S_RSPW: begin
                    if (rsp_valid && rsp_match[i]) begin
                        r_d.slot[i].st  = S_DONE;
                        r_d.slot[i].ppn = rsp_ppn;
                    end
                end
                S_DONE: begin
                    if (done_gnt[i]) r_d.slot[i].st = S_CLEAN;
                end
                S_CLEAN: r_d.slot[i].st = S_FREE;
                default: r_d.slot[i].st = S_FREE;
            endcase
        end
        r_d.outst    = r_q.outst + OC_W'(accept) - OC_W'(done_any);
        r_d.snd_busy = send_any && !down_ready;
        r_d.snd_idx  = sel_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    if (LAST_LEVEL) begin : g_walk
        assign walk_valid = send_any;
        assign walk_vpn   = r_q.slot[sel_idx].vpn;
        assign dn_valid   = 1'b0;
        assign dn_vpn     = '0;
    end else begin : g_lower
        assign dn_valid   = send_any;
        assign dn_vpn     = r_q.slot[sel_idx].vpn;
        assign walk_valid = 1'b0;
        assign walk_vpn   = '0;
    end

    assign ins_valid = rsp_hit;
    assign ins_vpn   = rsp_vpn;
    assign ins_ppn   = rsp_ppn;

    assign out_valid   = done_any;
    assign out_vpn     = r_q.slot[done_idx].vpn;
    assign out_ppn     = r_q.slot[done_idx].ppn;
    assign out_hit     = r_q.slot[done_idx].hit;
    assign out_lanes   = r_q.slot[done_idx].lanes;
    assign outstanding = r_q.outst;

    xmt_stats #(.LW(LANE_W), .CW(CNT_W), .OW(OC_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept),
        .is_hit   (tlb_hit),
        .is_pf    (req_prefetch),
        .lanes    (req_lanes),
        .outst_d  (r_d.outst),
        .hit_cnt  (hit_lanes),
        .miss_cnt (miss_lanes),
        .peak     (peak_outstanding)
    );
endmodule

// File: rtl/xmt_checker.sv
module xmt_checker #(
    parameter int MAX_OUT = 4,
    parameter int OC_W    = 3,
    parameter int VPN_W   = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             dup_err,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic [VPN_W-1:0] dn_vpn,
    input logic             walk_valid,
    input logic             rsp_valid,
    input logic             ins_valid,
    input logic             out_valid,
    input logic [OC_W-1:0]  outstanding,
    input logic [OC_W-1:0]  peak_outstanding
);
    a_r2_cap: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (outstanding < OC_W'(MAX_OUT)));

    a_r3_dup_refused: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |-> !req_ready);

    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && walk_valid));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_vpn)));

    a_r8_ins_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> rsp_valid);

    a_r9_return_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(req_valid && req_ready)) |=>
            (outstanding == $past(outstanding) - OC_W'(1)));

    a_r11_peak: assert property (@(posedge clk) disable iff (!rst_n)
        peak_outstanding >= outstanding);
endmodule

bind xmt_tracker xmt_checker #(
    .MAX_OUT (MAX_OUT),
    .OC_W    ($clog2(MAX_OUT + 1)),
    .VPN_W   (VPN_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .dup_err          (dup_err),
    .dn_valid         (dn_valid),
    .dn_ready         (dn_ready),
    .dn_vpn           (dn_vpn),
    .walk_valid       (walk_valid),
    .rsp_valid        (rsp_valid),
    .ins_valid        (ins_valid),
    .out_valid        (out_valid),
    .outstanding      (outstanding),
    .peak_outstanding (peak_outstanding)
);

// File: tb/xmt_tracker_test.sv
`timescale 1ns/1ps
module xmt_tracker_test;
    localparam int VW = 20, PW = 20, LW = 6, CW = 32, MO = 4, HL = 2, ML = 3;
    localparam int OW = $clog2(MO + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n;

    logic          req_valid, req_prefetch, tlb_hit, dn_ready, walk_ready, rsp_valid;
    logic [VW-1:0] req_vpn, rsp_vpn;
    logic [LW-1:0] req_lanes;
    logic [PW-1:0] tlb_ppn, rsp_ppn;
    logic          req_ready, dup_err, dn_valid, walk_valid, ins_valid, out_valid, out_hit;
    logic [VW-1:0] dn_vpn, walk_vpn, ins_vpn, out_vpn;
    logic [PW-1:0] ins_ppn, out_ppn;
    logic [LW-1:0] out_lanes;
    logic [OW-1:0] outstanding, peak_outstanding;
    logic [CW-1:0] hit_lanes, miss_lanes;

    xmt_tracker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_lanes(req_lanes), .req_prefetch(req_prefetch),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .dup_err(dup_err),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_vpn(dn_vpn),
        .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vpn(walk_vpn),
        .rsp_valid(rsp_valid), .rsp_vpn(rsp_vpn), .rsp_ppn(rsp_ppn),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .out_valid(out_valid), .out_vpn(out_vpn), .out_ppn(out_ppn),
        .out_hit(out_hit), .out_lanes(out_lanes), .outstanding(outstanding),
        .peak_outstanding(peak_outstanding), .hit_lanes(hit_lanes), .miss_lanes(miss_lanes)
    );

    // last-level variant
    logic          w_req_valid, w_dn_ready, w_walk_ready, w_rsp_valid;
    logic [VW-1:0] w_req_vpn, w_rsp_vpn;
    logic [PW-1:0] w_rsp_ppn;
    logic          w_req_ready, w_dup_err, w_dn_valid, w_walk_valid, w_ins_valid, w_out_valid, w_out_hit;
    logic [VW-1:0] w_dn_vpn, w_walk_vpn, w_ins_vpn, w_out_vpn;
    logic [PW-1:0] w_ins_ppn, w_out_ppn;
    logic [LW-1:0] w_out_lanes;
    logic [OW-1:0] w_outst, w_peak;
    logic [CW-1:0] w_hl, w_ml;

    xmt_tracker #(.LAST_LEVEL(1'b1)) walk_uut (
        .clk(clk), .rst_n(rst_n), .req_valid(w_req_valid), .req_ready(w_req_ready),
        .req_vpn(w_req_vpn), .req_lanes(6'd1), .req_prefetch(1'b0),
        .tlb_hit(1'b0), .tlb_ppn(20'h0), .dup_err(w_dup_err),
        .dn_valid(w_dn_valid), .dn_ready(w_dn_ready), .dn_vpn(w_dn_vpn),
        .walk_valid(w_walk_valid), .walk_ready(w_walk_ready), .walk_vpn(w_walk_vpn),
        .rsp_valid(w_rsp_valid), .rsp_vpn(w_rsp_vpn), .rsp_ppn(w_rsp_ppn),
        .ins_valid(w_ins_valid), .ins_vpn(w_ins_vpn), .ins_ppn(w_ins_ppn),
        .out_valid(w_out_valid), .out_vpn(w_out_vpn), .out_ppn(w_out_ppn),
        .out_hit(w_out_hit), .out_lanes(w_out_lanes), .outstanding(w_outst),
        .peak_outstanding(w_peak), .hit_lanes(w_hl), .miss_lanes(w_ml)
    );

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] exp_hit = '0, exp_miss = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [VW-1:0] vpn;
        logic          hit;
        logic [PW-1:0] ppn;
        logic          pf;
        logic [LW-1:0] lanes;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{20'h00010, 1'b1, 20'hA0010, 1'b0, 6'd4},
        '{20'h00011, 1'b0, 20'hB0011, 1'b0, 6'd7},
        '{20'h00012, 1'b1, 20'hA0012, 1'b1, 6'd9},
        '{20'h00013, 1'b0, 20'hB0013, 1'b1, 6'd3},
        '{20'hFFFFF, 1'b1, 20'h00001, 1'b0, 6'd63},
        '{20'h00000, 1'b0, 20'hFFFFF, 1'b0, 6'd1}
    };

    task automatic drive_req(input logic [VW-1:0] v, input logic h, input logic [PW-1:0] p,
                             input logic pf, input logic [LW-1:0] l);
        req_valid = 1'b1; req_vpn = v; tlb_hit = h; tlb_ppn = p;
        req_prefetch = pf; req_lanes = l;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        drive_req(v.vpn, v.hit, v.hit ? v.ppn : 20'h0, v.pf, v.lanes);
        #1 check("R2 idle ready", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (!v.pf) begin
            if (v.hit) exp_hit += CW'(v.lanes);
            else       exp_miss += CW'(v.lanes);
        end
        check("R10 hit lanes", hit_lanes, exp_hit);
        check("R10 miss lanes", miss_lanes, exp_miss);
        if (v.hit) begin
            repeat (HL - 1) @(negedge clk);
            check("R4 not early", 32'(out_valid), 0);
            @(negedge clk);
            check("R4 valid", 32'(out_valid), 1);
            check("R4 ppn", 32'(out_ppn), 32'(v.ppn));
            check("R4 vpn", 32'(out_vpn), 32'(v.vpn));
            check("R4 hit", 32'(out_hit), 1);
            check("R4 lanes", 32'(out_lanes), 32'(v.lanes));
        end else begin
            repeat (ML - 1) @(negedge clk);
            check("R5 not early", 32'(dn_valid), 0);
            @(negedge clk);
            check("R5 dn_valid", 32'(dn_valid), 1);
            check("R5 dn_vpn", 32'(dn_vpn), 32'(v.vpn));
            check("R6 walk idle", 32'(walk_valid), 0);
            dn_ready = 1'b1;
            @(negedge clk);
            dn_ready = 1'b0;
            check("R7 left", 32'(dn_valid), 0);
            rsp_valid = 1'b1; rsp_vpn = v.vpn; rsp_ppn = v.ppn;
            #1 check("R8 ins_valid", 32'(ins_valid), 1);
            check("R8 ins_ppn", 32'(ins_ppn), 32'(v.ppn));
            @(negedge clk);
            rsp_valid = 1'b0;
            check("R8 out_valid", 32'(out_valid), 1);
            check("R8 out_ppn", 32'(out_ppn), 32'(v.ppn));
            check("R8 out_hit", 32'(out_hit), 0);
        end
        @(negedge clk);
        check("R9 single pulse", 32'(out_valid), 0);
        check("R9 drained", 32'(outstanding), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_vpn = '0; req_lanes = '0; req_prefetch = 1'b0;
        tlb_hit = 1'b0; tlb_ppn = '0; dn_ready = 1'b0; walk_ready = 1'b0;
        rsp_valid = 1'b0; rsp_vpn = '0; rsp_ppn = '0;
        w_req_valid = 1'b0; w_req_vpn = '0; w_dn_ready = 1'b0; w_walk_ready = 1'b0;
        w_rsp_valid = 1'b0; w_rsp_vpn = '0; w_rsp_ppn = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 ready", 32'(req_ready), 1);
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 dn_valid", 32'(dn_valid), 0);
        check("R1 walk_valid", 32'(walk_valid), 0);
        check("R1 ins_valid", 32'(ins_valid), 0);
        check("R1 outstanding", 32'(outstanding), 0);
        check("R1 peak", 32'(peak_outstanding), 0);
        check("R1 counters", hit_lanes | miss_lanes, 0);

        foreach (VECS[k]) run_vec(VECS[k]);
        check("R11 peak after serial", 32'(peak_outstanding), 1);

        // fill to the cap with misses held below
        for (int k = 0; k < MO; k++) begin
            @(negedge clk);
            drive_req(20'h100 + 20'(k), 1'b0, 20'h0, 1'b1, 6'd2);
            #1 check("R2 ready below cap", 32'(req_ready), 1);
        end
        @(negedge clk);
        check("R2 outstanding full", 32'(outstanding), MO);
        drive_req(20'h200, 1'b0, 20'h0, 1'b1, 6'd2);
        #1 check("R2 refused at cap", 32'(req_ready), 0);
        check("R3 no dup on new page", 32'(dup_err), 0);
        req_vpn = 20'h101;
        #1 check("R3 dup_err", 32'(dup_err), 1);
        check("R3 dup refused", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 refused not taken", 32'(outstanding), MO);
        check("R11 peak at cap", 32'(peak_outstanding), MO);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check("R7 held valid", 32'(dn_valid), 1);
            check("R7 held vpn", 32'(dn_vpn), 32'h100);
            @(negedge clk);
        end
        dn_ready = 1'b1;
        for (int k = 0; k < MO; k++) begin
            check("R7 order", 32'(dn_vpn), 32'h100 + 32'(k));
            @(negedge clk);
        end
        dn_ready = 1'b0;
        check("R7 all sent", 32'(dn_valid), 0);

        rsp_valid = 1'b1; rsp_vpn = 20'h300; rsp_ppn = 20'h5;
        #1 check("R8 stray no insert", 32'(ins_valid), 0);
        @(negedge clk);
        check("R8 stray no response", 32'(out_valid), 0);
        rsp_vpn = 20'h102; rsp_ppn = 20'hC102;
        @(negedge clk);
        rsp_vpn = 20'h100; rsp_ppn = 20'hC100;
        check("R8 out 0x102", 32'(out_vpn), 32'h102);
        check("R8 out 0x102 ppn", 32'(out_ppn), 32'hC102);
        @(negedge clk);
        rsp_valid = 1'b0;
        check("R8 out 0x100", 32'(out_vpn), 32'h100);
        check("R9 count after one return", 32'(outstanding), MO - 1);
        @(negedge clk);
        check("R9 count after two returns", 32'(outstanding), MO - 2);
        drive_req(20'h100, 1'b0, 20'h0, 1'b0, 6'd1);
        #1 check("R3 page free after return", 32'(dup_err), 0);
        check("R3 page accepted again", 32'(req_ready), 1);
        req_valid = 1'b0;
        rsp_valid = 1'b1; rsp_vpn = 20'h101; rsp_ppn = 20'hC101;
        @(negedge clk);
        rsp_vpn = 20'h103; rsp_ppn = 20'hC103;
        check("R8 out 0x101", 32'(out_vpn), 32'h101);
        @(negedge clk);
        rsp_valid = 1'b0;
        check("R8 out 0x103", 32'(out_vpn), 32'h103);
        @(negedge clk);
        check("R9 fully drained", 32'(outstanding), 0);
        check("R10 prefetch left counters", miss_lanes, exp_miss);
        check("R11 peak kept", 32'(peak_outstanding), MO);

        // last-level variant
        w_req_valid = 1'b1; w_req_vpn = 20'h777;
        @(negedge clk);
        w_req_valid = 1'b0;
        repeat (ML) @(negedge clk);
        check("R6 walk_valid", 32'(w_walk_valid), 1);
        check("R6 walk_vpn", 32'(w_walk_vpn), 32'h777);
        check("R6 no lower-level request", 32'(w_dn_valid), 0);
        w_walk_ready = 1'b1;
        @(negedge clk);
        w_walk_ready = 1'b0;
        w_rsp_valid = 1'b1; w_rsp_vpn = 20'h777; w_rsp_ppn = 20'h1234;
        #1 check("R6 walk insert", 32'(w_ins_valid), 1);
        @(negedge clk);
        w_rsp_valid = 1'b0;
        check("R6 walk response", 32'(w_out_ppn), 32'h1234);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule